// File: doc/BRIEF.md
# Timer External Trigger Conditioner

This block turns a raw external event line into a clean trigger for a timer. It picks one candidate from a set of inputs: a device pin, two comparator outputs and three watchdog flags reached through a remap field. The chosen line passes through a two-stage synchronizer into the timer clock domain and can be inverted. Its rising edges can then be divided down by 1, 2, 4 or 8. A counting glitch filter follows. The filter samples only on cycles where a separate sample-enable strobe is high.

The result is a conditioned trigger level and a one-cycle pulse on each rising edge of that level. The timer's clock path, slave controller and PWM clear logic consume these outputs. All settings arrive as plain field values on input ports, and any of them may change at any time.

Top module: `trig_conditioner`

## Requirements
- R1: Source field codes: 0 selects the legacy path, 1 selects comparator 1, 2 selects comparator 2, and 3 to 7 select a constant low input.
- R2: On the legacy path, remap code 0 selects the pin and codes 1, 2, 3 select watchdog flag bits awdIn[0], awdIn[1], awdIn[2].
- R3: Toggling any input that is not selected produces no trigger edge.
- R4: With the invert bit set, the synchronized input is complemented, so each falling edge on the selected line counts as a rising trigger edge.
- R5: Divider codes 0, 1, 2, 3 produce one rising edge of the prescaled level for every 1, 2, 4, 8 rising input edges.
- R6: Any change of the divider code restarts the input edge count from zero.
- R7: Filter code 0 bypasses the filter, and the output follows the prescaled level every clock. Codes 1, 2, 3, 4, 5 require 1, 2, 4, 5, 6 consecutive differing samples before the output changes, and codes 6 to 15 require 8.
- R8: With a non-zero filter code, the filtered output does not change on a cycle where sampleEn is low.
- R9: With divider code 0 and filter code 0, trigOut goes high at the fourth rising clock edge, counting the first edge that samples the new input level.
- R10: trigEdge is high for exactly one cycle, in the first cycle that trigOut is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Filter sampling strobe |
| pinIn | input | 1 | External pin candidate |
| cmp1In | input | 1 | Comparator 1 candidate |
| cmp2In | input | 1 | Comparator 2 candidate |
| awdIn | input | 3 | Watchdog flag candidates |
| srcSel | input | 3 | Source field |
| remapSel | input | 2 | Legacy remap field |
| invert | input | 1 | Polarity inversion |
| divSel | input | 2 | Edge divider field |
| filtSel | input | 4 | Filter length field |
| trigOut | output | 1 | Conditioned trigger level |
| trigEdge | output | 1 | One-cycle pulse on rising trigOut |

## Verification
The assertions check several properties on every cycle. The edge pulse must stay within the first high cycle of the level. The filtered output must hold while sampling is off. The divider must emit only on an input rise. Each rise of the output must match the level the filter sampled. Other behaviours can only be shown by scenarios that count edges at the output: source and remap decoding, isolation of unselected inputs, the division ratios, the restart when the divider code changes, the filter length boundaries, and the exact latency.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
  localparam int SRC_LEGACY = 0;
  localparam int SRC_CMP1   = 1;
  localparam int SRC_CMP2   = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic emit;    // prescaler passes a rising edge
    logic take;    // filter accepts the prescaled level
    logic bypass;  // filter disabled
  } ctlStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic riseIn;      // rising edge of polarity-adjusted input
    logic prescLevel;  // prescaled level
    logic differ;      // prescaled level differs from filter output
  } dpStat_t;

  // number of agreeing samples required per filter code (R7)
  function automatic int filtLenOf(int code);
    case (code)
      0:       return 1;
      1:       return 1;
      2:       return 2;
      3:       return 4;
      4:       return 5;
      5:       return 6;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_cond_pkg::*;
#(
  parameter int DIV_W    = 2,
  parameter int FILT_W   = 4,
  parameter int MAX_FILT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic [DIV_W-1:0]  divSel,
  input  logic [FILT_W-1:0] filtSel,
  input  dpStat_t           stat,
  output ctlStrb_t          strb
);
  localparam int MAX_DIV = 1 << ((1 << DIV_W) - 1);
  localparam int EC_W    = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
  localparam int FC_W    = $clog2(MAX_FILT + 1);

  logic [EC_W-1:0]  edgeCnt;
  logic [EC_W-1:0]  lastIdx;
  logic [EC_W:0]    divN;
  logic [DIV_W-1:0] divPrev;
  logic             divChanged;
  logic [FC_W-1:0]  agreeCnt;
  logic [FC_W-1:0]  need;
  logic [FC_W-1:0]  needM1;

  // edge divider (R5, R6)
  always_comb begin
    divN       = (EC_W+1)'(1) << divSel;
    lastIdx    = EC_W'(divN - (EC_W+1)'(1));
    divChanged = (divSel != divPrev);
    strb.emit  = stat.riseIn && !divChanged && (edgeCnt == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
      divPrev <= '0;
    end else begin
      divPrev <= divSel;
      if (divChanged)
        edgeCnt <= '0;
      else if (stat.riseIn)
        edgeCnt <= (edgeCnt == lastIdx) ? '0 : edgeCnt + EC_W'(1);
    end
  end

  // glitch filter counter (R7, R8)
  always_comb begin
    need        = FC_W'(filtLenOf(int'(filtSel)));
    needM1      = need - FC_W'(1);
    strb.bypass = (filtSel == '0);
    strb.take   = !strb.bypass && sampleEn && stat.differ && (agreeCnt == needM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      agreeCnt <= '0;
    else if (strb.bypass || !stat.differ)
      agreeCnt <= '0;
    else if (sampleEn)
      agreeCnt <= strb.take ? '0 : agreeCnt + FC_W'(1);
  end
endmodule

// File: rtl/trig_dpath.sv
module trig_dpath
  import trig_cond_pkg::*;
#(
  parameter int NUM_AWD     = 3,
  parameter int REMAP_W     = 2,
  parameter int SRC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinIn,
  input  logic               cmp1In,
  input  logic               cmp2In,
  input  logic [NUM_AWD-1:0] awdIn,
  input  logic [SRC_W-1:0]   srcSel,
  input  logic [REMAP_W-1:0] remapSel,
  input  logic               invert,
  input  ctlStrb_t           strb,
  output dpStat_t            stat,
  output logic               trigOut,
  output logic               trigEdge
);
  logic                   legacy;
  logic                   picked;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   polLevel;
  logic                   polPrev;
  logic                   prescQ;
  logic                   filtQ;
  logic                   filtPrev;

  // source selection (R1, R2)
  always_comb begin
    legacy = 1'b0;
    if (remapSel == '0) legacy = pinIn;
    for (int i = 0; i < NUM_AWD; i++)
      if (remapSel == REMAP_W'(i + 1)) legacy = awdIn[i];
    case (int'(srcSel))
      SRC_LEGACY: picked = legacy;
      SRC_CMP1:   picked = cmp1In;
      SRC_CMP2:   picked = cmp2In;
      default:    picked = 1'b0;
    endcase
  end

  // synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk)
        if (!rstN) syncQ <= '0;
        else       syncQ <= picked;
    end else begin : g_syncN
      always_ff @(posedge clk)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], picked};
    end
  endgenerate

  // polarity (R4)
  assign polLevel = syncQ[SYNC_STAGES-1] ^ invert;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polPrev  <= 1'b0;
      prescQ   <= 1'b0;
      filtQ    <= 1'b0;
      filtPrev <= 1'b0;
    end else begin
      polPrev  <= polLevel;
      prescQ   <= polLevel & (strb.emit | prescQ);
      if (strb.bypass || strb.take)
        filtQ <= prescQ;
      filtPrev <= filtQ;
    end
  end

  assign stat.riseIn     = polLevel & ~polPrev;
  assign stat.prescLevel = prescQ;
  assign stat.differ     = prescQ ^ filtQ;
  assign trigOut         = filtQ;
  assign trigEdge        = filtQ & ~filtPrev;  // R10
endmodule

// File: rtl/trig_conditioner.sv
module trig_conditioner
  import trig_cond_pkg::*;
#(
  parameter int NUM_AWD     = 3,
  parameter int SRC_W       = 3,
  parameter int DIV_W       = 2,
  parameter int FILT_W      = 4,
  parameter int MAX_FILT    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int REMAP_W    = $clog2(NUM_AWD + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic               pinIn,
  input  logic               cmp1In,
  input  logic               cmp2In,
  input  logic [NUM_AWD-1:0] awdIn,
  input  logic [SRC_W-1:0]   srcSel,
  input  logic [REMAP_W-1:0] remapSel,
  input  logic               invert,
  input  logic [DIV_W-1:0]   divSel,
  input  logic [FILT_W-1:0]  filtSel,
  output logic               trigOut,
  output logic               trigEdge
);
  ctlStrb_t ctlStrb;
  dpStat_t  dpStat;

  trig_ctrl #(.DIV_W(DIV_W), .FILT_W(FILT_W), .MAX_FILT(MAX_FILT)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .divSel(divSel),
    .filtSel(filtSel), .stat(dpStat), .strb(ctlStrb)
  );

  trig_dpath #(.NUM_AWD(NUM_AWD), .REMAP_W(REMAP_W), .SRC_W(SRC_W),
               .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cmp1In(cmp1In), .cmp2In(cmp2In),
    .awdIn(awdIn), .srcSel(srcSel), .remapSel(remapSel), .invert(invert),
    .strb(ctlStrb), .stat(dpStat), .trigOut(trigOut), .trigEdge(trigEdge)
  );
endmodule

// File: rtl/trig_conditioner_chk.sv
module trig_conditioner_chk
  import trig_cond_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleEn,
  input logic [FILT_W-1:0] filtSel,
  input logic              trigOut,
  input logic              trigEdge,
  input ctlStrb_t          strb,
  input dpStat_t           stat
);
  assert_edge_with_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    trigEdge |-> trigOut);

  assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    trigEdge |=> !trigEdge);

  assert_hold_without_sample_R8: assert property (@(posedge clk) disable iff (!rstN)
    (filtSel != '0 && !sampleEn) |=> $stable(trigOut));

  assert_emit_on_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |-> stat.riseIn);

  assert_rise_follows_presc_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> $past(stat.prescLevel));
endmodule

bind trig_conditioner trig_conditioner_chk #(.FILT_W(FILT_W)) chk (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .filtSel(filtSel),
  .trigOut(trigOut), .trigEdge(trigEdge), .strb(ctlStrb), .stat(dpStat)
);

// File: tb/tb_trig_conditioner.sv
module tb_trig_conditioner;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b1;
  logic       pinIn = 1'b0, cmp1In = 1'b0, cmp2In = 1'b0;
  logic [2:0] awdIn = '0;
  logic [2:0] srcSel = '0;
  logic [1:0] remapSel = '0;
  logic       invert = 1'b0;
  logic [1:0] divSel = '0;
  logic [3:0] filtSel = '0;
  logic       trigOut, trigEdge;

  int checks = 0, fails = 0;
  int edgeCount = 0;
  logic clearReq = 1'b0;
  logic sparse = 1'b0;
  int phase = 0;

  typedef struct { int exp; string tag; } expItem_t;
  expItem_t expQ[$];

  trig_conditioner dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .pinIn(pinIn),
    .cmp1In(cmp1In), .cmp2In(cmp2In), .awdIn(awdIn), .srcSel(srcSel),
    .remapSel(remapSel), .invert(invert), .divSel(divSel),
    .filtSel(filtSel), .trigOut(trigOut), .trigEdge(trigEdge)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sampling strobe: every cycle, or one cycle in four when sparse
  always @(negedge clk) begin
    phase = (phase + 1) % 4;
    sampleEn = sparse ? (phase == 3) : 1'b1;
  end

  // monitor: count edge pulses and compare against expected items
  always @(negedge clk) begin
    if (clearReq) edgeCount = 0;
    else if (trigEdge) edgeCount++;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checkVal(it.tag, edgeCount, it.exp);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLine(int which, logic v);
    case (which)
      0: pinIn = v;
      1: cmp1In = v;
      2: cmp2In = v;
      default: awdIn[which-3] = v;
    endcase
  endtask

  task automatic configure(int src, int rmp, logic inv, int dv, int flt, logic pinIdle);
    @(negedge clk);
    srcSel = 3'(src); remapSel = 2'(rmp); invert = inv;
    divSel = 2'(dv); filtSel = 4'(flt); pinIn = pinIdle;
    idle(40);
  endtask

  task automatic startCount();
    clearReq = 1'b1;
    idle(2);
    clearReq = 1'b0;
  endtask

  task automatic pulses(int which, int n, int w, int gap, logic active);
    for (int i = 0; i < n; i++) begin
      setLine(which, active);
      idle(w);
      setLine(which, ~active);
      idle(gap);
    end
  endtask

  // driver side of the scoreboard
  task automatic expectEdges(string tag, int n);
    expItem_t it;
    it.exp = n; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
    idle(1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    checkVal("R9 reset trigOut", int'(trigOut), 0);
    checkVal("R10 reset trigEdge", int'(trigEdge), 0);
    rstN = 1'b1;
    idle(2);

    // R9 / R10 latency
    configure(0, 0, 0, 0, 0, 0);
    pinIn = 1'b1;   // sampled by the next edge (edge 1)
    idle(3);
    checkVal("R9 trigOut low after third edge", int'(trigOut), 0);
    idle(1);
    checkVal("R9 trigOut high after fourth edge", int'(trigOut), 1);
    checkVal("R10 trigEdge with first high cycle", int'(trigEdge), 1);
    idle(1);
    checkVal("R10 trigEdge one cycle", int'(trigEdge), 0);
    checkVal("R10 trigOut stays high", int'(trigOut), 1);
    pinIn = 1'b0;
    idle(20);

    // R1 / R2 pin source, divide by 1
    configure(0, 0, 0, 0, 0, 0);
    startCount(); pulses(0, 5, 4, 12, 1); expectEdges("R1 R2 pin edges", 5);

    // R5 ratios
    configure(0, 0, 0, 1, 0, 0);
    startCount(); pulses(0, 8, 4, 12, 1); expectEdges("R5 divide by 2", 4);
    configure(0, 0, 0, 2, 0, 0);
    startCount(); pulses(0, 8, 4, 12, 1); expectEdges("R5 divide by 4", 2);
    configure(0, 0, 0, 3, 0, 0);
    startCount(); pulses(0, 16, 4, 12, 1); expectEdges("R5 divide by 8", 2);

    // R1 comparators, R3 isolation
    configure(1, 0, 0, 0, 0, 0);
    startCount(); pulses(1, 3, 4, 12, 1); expectEdges("R1 comparator 1", 3);
    startCount(); pulses(0, 3, 4, 12, 1); pulses(2, 3, 4, 12, 1);
    expectEdges("R3 pin and cmp2 ignored", 0);
    configure(2, 0, 0, 0, 0, 0);
    startCount(); pulses(2, 3, 4, 12, 1); expectEdges("R1 comparator 2", 3);
    startCount(); pulses(1, 3, 4, 12, 1); expectEdges("R3 cmp1 ignored", 0);

    // R1 tied-low codes
    for (int code = 3; code < 8; code += 4) begin
      configure(code, 0, 0, 0, 0, 0);
      startCount();
      for (int ln = 0; ln < 6; ln++) pulses(ln, 2, 4, 12, 1);
      expectEdges("R1 tied-low source", 0);
    end

    // R2 watchdog remap
    for (int r = 1; r <= 3; r++) begin
      configure(0, r, 0, 0, 0, 0);
      startCount(); pulses(2 + r, 2, 4, 12, 1); expectEdges("R2 watchdog remap", 2);
    end
    configure(0, 2, 0, 0, 0, 0);
    startCount(); pulses(3, 2, 4, 12, 1); pulses(0, 2, 4, 12, 1);
    expectEdges("R3 other remap lines ignored", 0);

    // R4 inversion: low-going pulses count
    configure(0, 0, 1, 0, 0, 1);
    startCount(); pulses(0, 4, 4, 12, 0); expectEdges("R4 inverted edges", 4);
    configure(0, 0, 0, 0, 0, 0);

    // R6 divider restart
    configure(0, 0, 0, 2, 0, 0);
    startCount(); pulses(0, 3, 4, 12, 1);
    configure(0, 0, 0, 1, 0, 0);
    pulses(0, 2, 4, 12, 1);
    expectEdges("R6 count restarts on divider change", 1);

    // R7 filter lengths
    configure(0, 0, 0, 0, 0, 0);
    startCount(); pulses(0, 3, 1, 20, 1); expectEdges("R7 bypass passes 1-cycle", 3);
    configure(0, 0, 0, 0, 1, 0);
    startCount(); pulses(0, 3, 1, 20, 1); expectEdges("R7 code1 N=1", 3);
    configure(0, 0, 0, 0, 2, 0);
    startCount(); pulses(0, 3, 1, 20, 1); expectEdges("R7 code2 short", 0);
    startCount(); pulses(0, 3, 2, 20, 1); expectEdges("R7 code2 N=2", 3);
    configure(0, 0, 0, 0, 3, 0);
    startCount(); pulses(0, 3, 3, 20, 1); expectEdges("R7 code3 short", 0);
    startCount(); pulses(0, 3, 4, 20, 1); expectEdges("R7 code3 N=4", 3);
    configure(0, 0, 0, 0, 4, 0);
    startCount(); pulses(0, 2, 4, 20, 1); expectEdges("R7 code4 short", 0);
    startCount(); pulses(0, 2, 5, 20, 1); expectEdges("R7 code4 N=5", 2);
    configure(0, 0, 0, 0, 5, 0);
    startCount(); pulses(0, 2, 5, 20, 1); expectEdges("R7 code5 short", 0);
    startCount(); pulses(0, 2, 6, 20, 1); expectEdges("R7 code5 N=6", 2);
    configure(0, 0, 0, 0, 9, 0);
    startCount(); pulses(0, 2, 7, 24, 1); expectEdges("R7 code9 short", 0);
    startCount(); pulses(0, 2, 8, 24, 1); expectEdges("R7 code9 N=8", 2);

    // R8 sparse sampling
    sparse = 1'b1;
    configure(0, 0, 0, 0, 2, 0);
    startCount(); pulses(0, 2, 4, 40, 1); expectEdges("R8 one sample only", 0);
    startCount(); pulses(0, 2, 12, 40, 1); expectEdges("R8 enough samples", 2);
    sparse = 1'b0;

    finishRun();
  end
endmodule